// File: doc/BRIEF.md
# Iterative XTEA Cipher Engine

This block encrypts or decrypts one 64-bit block with the XTEA cipher under a 128-bit key. The block arrives as two 32-bit words and the result leaves as two 32-bit words. One input bit picks the direction. A single shared half-round datapath is reused on every clock, so the full 32-cycle cipher takes 64 clocks.

The engine works one operation per reset. When reset is released, the first rising edge captures the key, both data words and the direction. The engine then steps through the rounds and sets a completion flag. The flag and the result stay in place until reset is applied again. A new operation always begins with a reset pulse, and there is no streaming handshake.

Top module: `xtea_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the engine clears itself, so `done_o` is 0 and both result words read 0.
- R2: The key, both data words and `encrypt_i` are sampled only on the first rising edge with `rst_n` high; changing them afterwards has no effect on that operation's result.
- R3: `done_o` goes high on exactly the 65th rising edge after reset is released (64 edges after the capture edge), it is low before that, and it stays high until the next reset.
- R4: With `encrypt_i` = 1 the result is the XTEA ciphertext: 32 cycles, delta 0x9E3779B9, running sum starting at 0, key word 0 taken from `key_i[127:96]` and key word 3 from `key_i[31:0]`, `word0` acting as the first half (v0). An all-zero key and all-zero block give `word0_o` = 0xDEE9D4D8 and `word1_o` = 0xF7131ED9.
- R5: With `encrypt_i` = 0 the engine runs the inverse cipher, with the sum starting at 0xC6EF3720 and stepping down. Decrypting a ciphertext under the same key returns the original two words.
- R6: Once `done_o` is high, the result words hold their values and input changes neither alter them nor start a new operation.
- R7: A reset applied part-way through an operation abandons it. No completion is flagged for the abandoned operation, and the next operation after release produces its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; required before each operation |
| encrypt_i | input | 1 | Direction: 1 encrypts, 0 decrypts |
| key_i | input | 128 | Cipher key; bits 127:96 are key word 0 |
| word0_i | input | 32 | First half of the input block (v0) |
| word1_i | input | 32 | Second half of the input block (v1) |
| word0_o | output | 32 | First half of the result |
| word1_o | output | 32 | Second half of the result |
| done_o | output | 1 | Sticky completion flag; result valid while high |

## Verification
The all-zero known answer catches a swapped key-word order, a wrong shift, or a sum that is advanced before or after the wrong half-step, because any of these gives a different ciphertext. Round-trip runs under several keys expose a decrypt path that walks the schedule in the wrong order or starts from the wrong sum, since the plaintext would then not come back. Scrambling the inputs every cycle after capture shows whether an engine reads its ports live instead of holding a captured copy. Counting edges to the flag, and holding inputs after completion, catch an off-by-one round count, a flag that drops, and an engine that restarts without a reset. A reset in the middle of a run checks that a half-finished run leaves nothing behind.

// File: rtl/xtea_pkg.sv
package xtea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xt_state_e;

    localparam int unsigned XT_SHL     = 4;
    localparam int unsigned XT_SHR     = 5;
    localparam int unsigned XT_HI_IDX  = 11;

endpackage

// File: rtl/xtea_key_select.sv
module xtea_key_select #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned KEY_WORDS = 4,
    parameter int unsigned HI_SHIFT  = 11
) (
    input  logic [WORD_W*KEY_WORDS-1:0] key_i,
    input  logic [WORD_W-1:0]           sum_i,
    input  logic                        hi_sel_i,
    output logic [WORD_W-1:0]           kw_o
);
    localparam int unsigned IDX_W = $clog2(KEY_WORDS);

    logic [WORD_W-1:0] words [KEY_WORDS];
    logic [IDX_W-1:0]  idx;

    // word 0 sits in the most significant slice of the key
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_split
        assign words[g] = key_i[WORD_W*(KEY_WORDS-g)-1 -: WORD_W];
    end

    assign idx  = hi_sel_i ? sum_i[HI_SHIFT +: IDX_W] : sum_i[IDX_W-1:0];
    assign kw_o = words[idx];

endmodule

// File: rtl/xtea_round_unit.sv
module xtea_round_unit #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SHL    = 4,
    parameter int unsigned SHR    = 5
) (
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] dst_i,
    input  logic [WORD_W-1:0] sum_i,
    input  logic [WORD_W-1:0] kw_i,
    input  logic              sub_i,
    output logic [WORD_W-1:0] dst_o
);
    logic [WORD_W-1:0] spread;
    logic [WORD_W-1:0] mix;

    assign spread = ((src_i << SHL) ^ (src_i >> SHR)) + src_i;
    assign mix    = spread ^ (sum_i + kw_i);
    assign dst_o  = sub_i ? (dst_i - mix) : (dst_i + mix);

endmodule

// File: rtl/xtea_core.sv
module xtea_core #(
    parameter int unsigned      WORD_W     = 32,
    parameter int unsigned      KEY_WORDS  = 4,
    parameter int unsigned      NUM_CYCLES = 32,
    parameter logic [WORD_W-1:0] DELTA     = 32'h9E3779B9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        encrypt_i,
    input  logic [WORD_W*KEY_WORDS-1:0] key_i,
    input  logic [WORD_W-1:0]           word0_i,
    input  logic [WORD_W-1:0]           word1_i,
    output logic [WORD_W-1:0]           word0_o,
    output logic [WORD_W-1:0]           word1_o,
    output logic                        done_o
);
    import xtea_pkg::*;

    localparam int unsigned NUM_STEPS = 2 * NUM_CYCLES;
    localparam int unsigned CNT_W     = $clog2(NUM_STEPS);
    localparam logic [63:0] SUM_FULL  = 64'(DELTA) * 64'(NUM_CYCLES);
    localparam logic [WORD_W-1:0] SUM_DEC_INIT = SUM_FULL[WORD_W-1:0];
    localparam logic [CNT_W-1:0]  LAST_STEP    = CNT_W'(NUM_STEPS - 1);

    typedef struct packed {
        xt_state_e         st;
        logic              enc;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sum;
        logic [WORD_W-1:0] v0;
        logic [WORD_W-1:0] v1;
    } xt_reg_t;

    localparam xt_reg_t REG_RST = '{st: ST_IDLE, enc: 1'b0, cnt: '0,
                                    sum: '0, v0: '0, v1: '0};

    xt_reg_t           cur_q;
    xt_reg_t           nxt_d;

    logic              phase;
    logic              upd_v0;
    logic              hi_sel;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] kw;
    logic [WORD_W-1:0] dst_new;

    // step order: encrypt touches v0 then v1, decrypt touches v1 then v0
    assign phase  = cur_q.cnt[0];
    assign upd_v0 = cur_q.enc ? ~phase : phase;
    assign hi_sel = cur_q.enc ? phase : ~phase;
    assign src    = upd_v0 ? cur_q.v1 : cur_q.v0;
    assign dst    = upd_v0 ? cur_q.v0 : cur_q.v1;

    xtea_key_select #(
        .WORD_W    (WORD_W),
        .KEY_WORDS (KEY_WORDS),
        .HI_SHIFT  (XT_HI_IDX)
    ) u_ksel (
        .key_i    (key_i_q),
        .sum_i    (cur_q.sum),
        .hi_sel_i (hi_sel),
        .kw_o     (kw)
    );

    xtea_round_unit #(
        .WORD_W (WORD_W),
        .SHL    (XT_SHL),
        .SHR    (XT_SHR)
    ) u_round (
        .src_i (src),
        .dst_i (dst),
        .sum_i (cur_q.sum),
        .kw_i  (kw),
        .sub_i (~cur_q.enc),
        .dst_o (dst_new)
    );

    always_comb begin
        nxt_d     = cur_q;
        key_d     = key_i_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                nxt_d.st  = ST_RUN;
                nxt_d.enc = encrypt_i;
                nxt_d.v0  = word0_i;
                nxt_d.v1  = word1_i;
                nxt_d.cnt = '0;
                nxt_d.sum = encrypt_i ? '0 : SUM_DEC_INIT;
                key_d     = key_i;
            end
            ST_RUN: begin
                if (upd_v0) begin
                    nxt_d.v0 = dst_new;
                end else begin
                    nxt_d.v1 = dst_new;
                end
                if (!phase) begin
                    nxt_d.sum = cur_q.enc ? (cur_q.sum + DELTA) : (cur_q.sum - DELTA);
                end
                nxt_d.cnt = cur_q.cnt + 1'b1;
                if (cur_q.cnt == LAST_STEP) begin
                    nxt_d.st = ST_DONE;
                end
            end
            default: begin
                nxt_d = cur_q;
            end
        endcase
    end

    logic [WORD_W*KEY_WORDS-1:0] key_i_q;
    logic [WORD_W*KEY_WORDS-1:0] key_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= REG_RST;
            key_i_q <= '0;
        end else begin
            cur_q   <= nxt_d;
            key_i_q <= key_d;
        end
    end

    assign word0_o = cur_q.v0;
    assign word1_o = cur_q.v1;
    assign done_o  = (cur_q.st == ST_DONE);

endmodule

// File: rtl/xtea_core_chk.sv
module xtea_core_chk #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned NUM_CYCLES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [WORD_W-1:0] word0_o,
    input logic [WORD_W-1:0] word1_o
);
    localparam int unsigned DONE_EDGE = 2 * NUM_CYCLES + 1;
    localparam int unsigned CK_W      = $clog2(DONE_EDGE + 1);
    localparam logic [CK_W-1:0] CK_DONE = CK_W'(DONE_EDGE);

    logic [CK_W-1:0] ck_q;

    // edges seen since reset release, saturating at the completion edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= '0;
        end else if (ck_q != CK_DONE) begin
            ck_q <= ck_q + 1'b1;
        end
    end

    a_r3_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_q < CK_DONE) |-> !done_o);

    a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_q == CK_DONE) |-> done_o);

    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ($stable(word0_o) && $stable(word1_o)));

endmodule

bind xtea_core xtea_core_chk #(
    .WORD_W     (WORD_W),
    .NUM_CYCLES (NUM_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_o  (done_o),
    .word0_o (word0_o),
    .word1_o (word1_o)
);

// File: tb/xtea_core_tb.sv
module xtea_core_tb;

    localparam logic [31:0] DLT = 32'h9E3779B9;
    localparam int DONE_EDGES  = 65;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         encrypt_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [31:0]  word0_i = '0;
    logic [31:0]  word1_i = '0;
    logic [31:0]  word0_o;
    logic [31:0]  word1_o;
    logic         done_o;

    xtea_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .encrypt_i (encrypt_i),
        .key_i     (key_i),
        .word0_i   (word0_i),
        .word1_i   (word1_i),
        .word0_o   (word0_o),
        .word1_o   (word1_o),
        .done_o    (done_o)
    );

    always #4 clk = ~clk;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  finished = 1'b0;
    int  edges    = 0;
    bit  seen     = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t item;

    always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fmix(input logic [31:0] x, input logic [31:0] s,
                                         input logic [31:0] k);
        return (((x << 4) ^ (x >> 5)) + x) ^ (s + k);
    endfunction

    function automatic logic [63:0] xtea_model(input logic [127:0] k, input logic [31:0] a,
                                               input logic [31:0] b, input bit enc);
        logic [31:0] kw [4];
        logic [31:0] s;
        logic [31:0] y;
        logic [31:0] z;
        for (int i = 0; i < 4; i++) kw[i] = k[127-32*i -: 32];
        y = a;
        z = b;
        if (enc) begin
            s = '0;
            for (int r = 0; r < 32; r++) begin
                y = y + fmix(z, s, kw[s[1:0]]);
                s = s + DLT;
                z = z + fmix(y, s, kw[s[12:11]]);
            end
        end else begin
            s = DLT << 5;
            for (int r = 0; r < 32; r++) begin
                z = z - fmix(y, s, kw[s[12:11]]);
                s = s - DLT;
                y = y - fmix(z, s, kw[s[1:0]]);
            end
        end
        return {y, z};
    endfunction

    // monitor: pops the scoreboard when the completion flag first appears
    always @(negedge clk) begin
        if (!rst_n) begin
            seen = 1'b0;
        end else if (done_o && !seen) begin
            seen = 1'b1;
            check(edges == DONE_EDGES, "R3", "edges to done", 64'(edges), 64'(DONE_EDGES));
            if (sbq.size() == 0) begin
                check(1'b0, "R7", "done with nothing pending", {word0_o, word1_o}, 64'h0);
            end else begin
                item = sbq.pop_front();
                check({word0_o, word1_o} === item.exp, item.tag, "result",
                      {word0_o, word1_o}, item.exp);
            end
        end
    end

    task automatic reset_and_load(input logic [127:0] k, input logic [31:0] a,
                                  input logic [31:0] b, input bit enc);
        @(negedge clk);
        rst_n     = 1'b0;
        key_i     = k;
        word0_i   = a;
        word1_i   = b;
        encrypt_i = enc;
        @(negedge clk);
        check(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 64'h0);
        check({word0_o, word1_o} == 64'h0, "R1", "words in reset", {word0_o, word1_o}, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic run_op(input logic [127:0] k, input logic [31:0] a, input logic [31:0] b,
                          input bit enc, input logic [63:0] exp, input string tag,
                          input bit scramble);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        sbq.push_back(e);
        reset_and_load(k, a, b, enc);
        for (int i = 0; i < 200 && sbq.size() != 0; i++) begin
            @(negedge clk);
            if (scramble) begin
                key_i     = {key_i[126:0], ~key_i[127]} ^ 128'h5A;
                word0_i   = word0_i + 32'h1357_9BDF;
                word1_i   = ~word1_i;
                encrypt_i = ~encrypt_i;
            end
        end
        if (sbq.size() != 0) begin
            check(1'b0, "R3", "no completion", 64'h0, exp);
            sbq.delete();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] keys [4];
        logic [63:0]  pts  [4];
        logic [63:0]  ct;

        keys[0] = 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F;
        keys[1] = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
        keys[2] = 128'h2BD6_459F_82C5_B300_952C_4910_4881_FF48;
        keys[3] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
        pts[0]  = 64'h4142_4344_4546_4748;
        pts[1]  = 64'h0000_0000_0000_0000;
        pts[2]  = 64'hEA02_4714_AD5C_4D84;
        pts[3]  = 64'hFFFF_FFFF_0000_0001;

        // R4: model agrees with the known answer, then the engine does too
        check(xtea_model('0, '0, '0, 1'b1) == 64'hDEE9D4D8_F7131ED9, "R4", "model KAT",
              xtea_model('0, '0, '0, 1'b1), 64'hDEE9D4D8_F7131ED9);
        run_op('0, '0, '0, 1'b1, 64'hDEE9D4D8_F7131ED9, "R4", 1'b0);

        // R4 and R5: encrypt, then decrypt back, under several keys
        for (int i = 0; i < 4; i++) begin
            ct = xtea_model(keys[i], pts[i][63:32], pts[i][31:0], 1'b1);
            run_op(keys[i], pts[i][63:32], pts[i][31:0], 1'b1, ct, "R4", 1'b0);
            run_op(keys[i], ct[63:32], ct[31:0], 1'b0, pts[i], "R5", 1'b0);
        end

        // R2: inputs scrambled every cycle after capture
        ct = xtea_model(keys[2], pts[0][63:32], pts[0][31:0], 1'b1);
        run_op(keys[2], pts[0][63:32], pts[0][31:0], 1'b1, ct, "R2", 1'b1);
        run_op(keys[2], ct[63:32], ct[31:0], 1'b0, pts[0], "R2", 1'b1);

        // R6: after completion, new inputs neither change nor restart anything
        run_op(keys[0], pts[2][63:32], pts[2][31:0], 1'b1,
               xtea_model(keys[0], pts[2][63:32], pts[2][31:0], 1'b1), "R6", 1'b0);
        ct = {word0_o, word1_o};
        @(negedge clk);
        key_i     = ~key_i;
        word0_i   = 32'hCAFE_0000;
        word1_i   = 32'h0000_BEEF;
        encrypt_i = 1'b0;
        repeat (80) @(negedge clk);
        check(done_o == 1'b1, "R6", "done held", 64'(done_o), 64'h1);
        check({word0_o, word1_o} == ct, "R6", "result held", {word0_o, word1_o}, ct);

        // R7: reset in mid-run, then a fresh operation
        reset_and_load(keys[1], pts[3][63:32], pts[3][31:0], 1'b1);
        repeat (20) @(negedge clk);
        check(done_o == 1'b0, "R7", "no done mid-run", 64'(done_o), 64'h0);
        run_op(keys[3], pts[3][63:32], pts[3][31:0], 1'b1,
               xtea_model(keys[3], pts[3][63:32], pts[3][31:0], 1'b1), "R7", 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule